// File: doc/BRIEF.md
# Dual-Mode Clock-Crossing FIFO

This block is a first-in first-out buffer that moves words from a write clock domain to a read clock domain. The two clocks may be unrelated or may be one shared clock. At master reset it latches one of two read disciplines, and keeps it until the next master reset.

In request mode every word, the first included, reaches the read data register only when a read is requested. The read-side status pin is an active-low empty flag. The write-side status pin is an active-low full flag. In fall-through mode the oldest word moves into the read data register without a request. The read-side pin then reads low while a valid word is presented. The write-side pin reads low while there is room. Because the presented word no longer occupies the storage array, fall-through mode holds one word more than request mode.

The ports are not valid/ready handshakes, and back-pressure works through the two status pins. A producer may pulse the write enable at any time. The block drops the word whenever it judges itself full, so the producer must hold off while the write-side pin reports no room. A consumer issues reads only while the read-side pin reports data. A read against an empty buffer changes nothing. Read and write pointers cross the domains as Gray code through a parameterised chain of synchronising registers, with a default of two.

Top module: `dfifo_dual_mode`

## Requirements
- R1: `fwft_sel` is captured on clock edges while `mrs_n` is low: 0 selects request mode and 1 selects fall-through mode. The mode then holds. After reset in request mode, `rd_flag`=0 and `wr_flag`=1. After reset in fall-through mode, `rd_flag`=1 and `wr_flag`=0.
- R2: In request mode, `rd_flag`=1 means not empty. A rising `rclk` edge with `ren_n`=0 and `rcs_n`=0 while not empty loads the oldest word into `rdata` on that edge. A read request while empty leaves `rdata` and the flags unchanged.
- R3: In request mode, with no reads after reset, `wr_flag` falls to 0 on the DEPTH-th write edge. A write while full is dropped and is never read out.
- R4: In fall-through mode, the first word written to an empty buffer appears on `rdata`, with `rd_flag` going 0, at the third rising `rclk` edge after the write edge when both ports share one clock. No read request is needed.
- R5: In fall-through mode, with no reads, `wr_flag` rises to 1 on the (DEPTH+1)-th write and stays 0 before it. A write while `wr_flag`=1 is dropped.
- R6: In fall-through mode, `rd_flag` returns to 1 only on an `rclk` edge with `ren_n`=0 and `rcs_n`=0 while the last word is presented, and `rdata` keeps that word. A true read while more words are stored presents the next word on the same edge.
- R7: When one shared clock is used and SYNC_STAGES=2, news crossing domains arrives two destination edges after its cause. In request mode `rd_flag` rises after the second `rclk` edge following the first write. `wr_flag` rises after the second `wclk` edge following a read from full.
- R8: `rcs_n`=1 blocks reads: with `ren_n`=0, no word is taken. `rcs_n` has no effect on flags or on fall-through, so a word that falls through while `rcs_n`=1 is still presented later.
- R9: While `ren_n`=1, `rdata` holds its value.
- R10: Words leave in the order they were accepted, across pointer wrap-around, in both modes and with independent clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wen_n | input | 1 | Write enable, active low |
| wdata | input | WIDTH | Write data |
| wr_flag | output | 1 | Request mode: 0 = full. Fall-through mode: 0 = room available |
| rclk | input | 1 | Read clock |
| ren_n | input | 1 | Read enable, active low |
| rcs_n | input | 1 | Read chip select, active low |
| rdata | output | WIDTH | Read data register |
| rd_flag | output | 1 | Request mode: 0 = empty. Fall-through mode: 0 = valid word on `rdata` |
| mrs_n | input | 1 | Master reset, active low, asynchronous assert |
| fwft_sel | input | 1 | Mode choice, sampled during reset |

## Verification
The assertions assume that `mrs_n` stays low across several edges of both clocks, so that each domain captures the mode. They also assume that `fwft_sel` is not relied on after release, and that all control inputs change away from the clock edge that samples them. Under those conditions, each pointer seen across the boundary moves one Gray step at a time. The occupancy seen from either side then stays between zero and DEPTH.

The stimulus changes every input just after a falling edge. It switches the read-clock source only while reset is held. In the streaming runs, the producer and consumer act only on what the status pins currently report.

// File: rtl/dfifo_pkg.sv
`timescale 1ns/1ps
package dfifo_pkg;
  typedef enum logic {
    MODE_REQ  = 1'b0,
    MODE_FALL = 1'b1
  } rd_mode_e;

  localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/dfifo_ptr_sync.sv
`timescale 1ns/1ps
module dfifo_ptr_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int NST = (STAGES < dfifo_pkg::MIN_SYNC_STAGES) ?
                       dfifo_pkg::MIN_SYNC_STAGES : STAGES;

  logic [NST-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < NST; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[NST-1];
endmodule

// File: rtl/dfifo_mem.sv
`timescale 1ns/1ps
module dfifo_mem #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dfifo_wr_ctrl.sv
`timescale 1ns/1ps
module dfifo_wr_ctrl
  import dfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input  logic          wclk,
  input  logic          mrs_n,
  input  logic          fwft_sel,
  input  logic          wen_n,
  input  logic [PW-1:0] rgray_sync,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          we,
  output logic          wr_flag
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  rd_mode_e      mode_w;
  logic [PW-1:0] rbin_seen;
  logic [PW-1:0] wbin_nx;
  logic          full;

  always_ff @(posedge wclk) begin
    if (!mrs_n) mode_w <= rd_mode_e'(fwft_sel);
  end

  assign rbin_seen = g2b(rgray_sync);
  assign full      = (wbin - rbin_seen) == PW'(DEPTH);
  assign we        = !wen_n && !full;
  assign wbin_nx   = wbin + PW'(1);

  always_ff @(posedge wclk or negedge mrs_n) begin
    if (!mrs_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  assign wr_flag = (mode_w == MODE_FALL) ? full : !full;

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!mrs_n)
    (wbin - rbin_seen) <= PW'(DEPTH));

  assert_mode_hold_R1: assert property (@(posedge wclk) disable iff (!mrs_n)
    $stable(mode_w));

  assert_gray_step_R10: assert property (@(posedge wclk) disable iff (!mrs_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dfifo_rd_ctrl.sv
`timescale 1ns/1ps
module dfifo_rd_ctrl
  import dfifo_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input  logic             rclk,
  input  logic             mrs_n,
  input  logic             fwft_sel,
  input  logic             ren_n,
  input  logic             rcs_n,
  input  logic [PW-1:0]    wgray_sync,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic [PW-1:0]    rbin,
  output logic [PW-1:0]    rgray,
  output logic [WIDTH-1:0] rdata,
  output logic             rd_flag
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  rd_mode_e      mode_r;
  logic [PW-1:0] wbin_seen;
  logic [PW-1:0] rbin_nx;
  logic          avail;
  logic          req;
  logic          out_valid;
  logic          true_rd;
  logic          pop;

  always_ff @(posedge rclk) begin
    if (!mrs_n) mode_r <= rd_mode_e'(fwft_sel);
  end

  assign wbin_seen = g2b(wgray_sync);
  assign avail     = wbin_seen != rbin;
  assign req       = !ren_n && !rcs_n;
  assign true_rd   = out_valid && req;
  assign rbin_nx   = rbin + PW'(1);

  always_comb begin
    if (mode_r == MODE_FALL) pop = avail && (!out_valid || true_rd);
    else                     pop = avail && req;
  end

  always_ff @(posedge rclk or negedge mrs_n) begin
    if (!mrs_n) begin
      rbin      <= '0;
      rgray     <= '0;
      rdata     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (pop) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
        rdata <= mem_rdata;
      end
      if (mode_r == MODE_FALL) begin
        if (pop)          out_valid <= 1'b1;
        else if (true_rd) out_valid <= 1'b0;
      end
    end
  end

  assign rd_flag = (mode_r == MODE_FALL) ? !out_valid : avail;

  assert_no_underflow_R2: assert property (@(posedge rclk) disable iff (!mrs_n)
    (wbin_seen - rbin) <= PW'(DEPTH));

  assert_fall_through_R4: assert property (@(posedge rclk) disable iff (!mrs_n)
    (mode_r == MODE_FALL && !out_valid && avail) |=> out_valid);

  assert_ready_drop_R6: assert property (@(posedge rclk) disable iff (!mrs_n)
    (mode_r == MODE_FALL && $fell(out_valid)) |-> ($past(ren_n) == 1'b0 && $past(rcs_n) == 1'b0));

  assert_req_hold_R9: assert property (@(posedge rclk) disable iff (!mrs_n)
    (mode_r == MODE_REQ && !$stable(rdata)) |-> ($past(ren_n) == 1'b0 && $past(rcs_n) == 1'b0));

  assert_mode_hold_R1: assert property (@(posedge rclk) disable iff (!mrs_n)
    $stable(mode_r));
endmodule

// File: rtl/dfifo_dual_mode.sv
`timescale 1ns/1ps
module dfifo_dual_mode #(
  parameter int WIDTH       = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wclk,
  input  logic             wen_n,
  input  logic [WIDTH-1:0] wdata,
  output logic             wr_flag,
  input  logic             rclk,
  input  logic             ren_n,
  input  logic             rcs_n,
  output logic [WIDTH-1:0] rdata,
  output logic             rd_flag,
  input  logic             mrs_n,
  input  logic             fwft_sel
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]    wbin, wgray, rbin, rgray;
  logic [PW-1:0]    wgray_r, rgray_w;
  logic             we;
  logic [WIDTH-1:0] mem_q;

  dfifo_wr_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_wr (
    .wclk(wclk), .mrs_n(mrs_n), .fwft_sel(fwft_sel), .wen_n(wen_n),
    .rgray_sync(rgray_w), .wbin(wbin), .wgray(wgray), .we(we), .wr_flag(wr_flag)
  );

  dfifo_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(mrs_n), .d(rgray), .q(rgray_w)
  );

  dfifo_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(mrs_n), .d(wgray), .q(wgray_r)
  );

  dfifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk(wclk), .we(we), .waddr(wbin[AW-1:0]), .wdata(wdata),
    .raddr(rbin[AW-1:0]), .rdata(mem_q)
  );

  dfifo_rd_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_rd (
    .rclk(rclk), .mrs_n(mrs_n), .fwft_sel(fwft_sel), .ren_n(ren_n), .rcs_n(rcs_n),
    .wgray_sync(wgray_r), .mem_rdata(mem_q), .rbin(rbin), .rgray(rgray),
    .rdata(rdata), .rd_flag(rd_flag)
  );
endmodule

// File: tb/sim_dfifo_dual_mode.sv
`timescale 1ns/1ps
module sim_dfifo_dual_mode;
  localparam int WIDTH = 16;
  localparam int DEPTH = 16;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic use_alt = 1'b0;
  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  logic wclk, rclk;
  assign wclk = clk_a;
  assign rclk = use_alt ? clk_b : clk_a;

  logic             wen_n = 1'b1, ren_n = 1'b1, rcs_n = 1'b1;
  logic             mrs_n = 1'b0, fwft_sel = 1'b0;
  logic [WIDTH-1:0] wdata = '0;
  logic [WIDTH-1:0] rdata;
  logic             wr_flag, rd_flag;

  int checks = 0;
  int errors = 0;

  dfifo_dual_mode #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SYNC_STAGES(2)) u0 (
    .wclk(wclk), .wen_n(wen_n), .wdata(wdata), .wr_flag(wr_flag),
    .rclk(rclk), .ren_n(ren_n), .rcs_n(rcs_n), .rdata(rdata), .rd_flag(rd_flag),
    .mrs_n(mrs_n), .fwft_sel(fwft_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit mode, input bit alt);
    mrs_n = 1'b0; fwft_sel = mode; use_alt = alt;
    wen_n = 1'b1; ren_n = 1'b1; rcs_n = 1'b1;
    repeat (8) @(negedge clk_a);
    mrs_n = 1'b1;
    fwft_sel = ~mode;
    repeat (2) @(negedge clk_a);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_a);
  endtask

  task automatic wr1(input logic [WIDTH-1:0] v);
    wen_n = 1'b0; wdata = v;
    @(negedge clk_a);
    wen_n = 1'b1;
  endtask

  task automatic rd1(input logic cs_n);
    ren_n = 1'b0; rcs_n = cs_n;
    @(negedge rclk);
    ren_n = 1'b1; rcs_n = 1'b1;
  endtask

  task automatic stream(input bit mode);
    do_reset(mode, 1'b1);
    fork
      begin : writer
        int n = 0;
        while (n < 40) begin
          @(negedge clk_a);
          if (wr_flag == (mode ? 1'b0 : 1'b1)) begin
            wen_n = 1'b0; wdata = WIDTH'(16'h300 + n); n++;
          end else wen_n = 1'b1;
        end
        @(negedge clk_a);
        wen_n = 1'b1;
      end
      begin : reader
        int m = 0;
        bit pend = 0;
        while (m < 40 || pend) begin
          @(negedge rclk);
          if (!mode) begin
            if (pend) begin
              chk("R10 request-mode order", 32'(rdata), 32'(16'h300 + m - 1));
              pend = 0;
            end
            if (m < 40 && rd_flag) begin
              ren_n = 1'b0; rcs_n = 1'b0; pend = 1; m++;
            end else begin
              ren_n = 1'b1; rcs_n = 1'b1;
            end
          end else begin
            if (rd_flag == 1'b0) begin
              chk("R10 fall-through order", 32'(rdata), 32'(16'h300 + m));
              ren_n = 1'b0; rcs_n = 1'b0; m++;
            end else begin
              ren_n = 1'b1; rcs_n = 1'b1;
            end
          end
        end
        @(negedge rclk);
        ren_n = 1'b1; rcs_n = 1'b1;
      end
    join
  endtask

  initial begin
    #200us;
    errors++; checks++;
    $display("FAIL watchdog (R10 run hung): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // request mode: reset state
    do_reset(1'b0, 1'b0);
    chk("R1 req rd_flag", 32'(rd_flag), 32'd0);
    chk("R1 req wr_flag", 32'(wr_flag), 32'd1);

    // first write crosses in two edges
    wr1(16'h00A1);
    chk("R7 empty after edge 0", 32'(rd_flag), 32'd0);
    idle(1);
    chk("R7 empty after edge 1", 32'(rd_flag), 32'd0);
    idle(1);
    chk("R7 not empty after edge 2", 32'(rd_flag), 32'd1);
    rd1(1'b1);
    chk("R8 no read with rcs_n high", 32'(rdata), 32'd0);
    chk("R8 flag unchanged", 32'(rd_flag), 32'd1);
    rd1(1'b0);
    chk("R2 read data", 32'(rdata), 32'h00A1);
    chk("R2 empty after last read", 32'(rd_flag), 32'd0);
    rd1(1'b0);
    chk("R2 read while empty ignored", 32'(rdata), 32'h00A1);

    // fill to full
    for (int i = 0; i < DEPTH; i++) begin
      wr1(WIDTH'(16'h100 + i));
      chk("R3 full flag during fill", 32'(wr_flag), (i == DEPTH - 1) ? 32'd0 : 32'd1);
    end
    wr1(16'h0BAD);
    chk("R3 stays full", 32'(wr_flag), 32'd0);
    idle(3);
    rd1(1'b0);
    chk("R2 oldest first", 32'(rdata), 32'h0100);
    chk("R7 full after read edge 0", 32'(wr_flag), 32'd0);
    idle(1);
    chk("R7 full after read edge 1", 32'(wr_flag), 32'd0);
    idle(1);
    chk("R7 room after read edge 2", 32'(wr_flag), 32'd1);
    idle(3);
    chk("R9 hold without ren", 32'(rdata), 32'h0100);
    for (int i = 1; i < DEPTH; i++) begin
      rd1(1'b0);
      chk("R3 drained word", 32'(rdata), 32'(16'h100 + i));
    end
    chk("R3 dropped write not stored", 32'(rd_flag), 32'd0);
    rd1(1'b0);
    chk("R3 no extra word", 32'(rdata), 32'(16'h100 + DEPTH - 1));

    // fall-through mode: reset state and first-word latency
    do_reset(1'b1, 1'b0);
    chk("R1 fall rd_flag", 32'(rd_flag), 32'd1);
    chk("R1 fall wr_flag", 32'(wr_flag), 32'd0);
    wr1(16'h00A5);
    idle(2);
    chk("R4 not yet at edge 2", 32'(rd_flag), 32'd1);
    idle(1);
    chk("R4 ready at edge 3", 32'(rd_flag), 32'd0);
    chk("R4 data at edge 3", 32'(rdata), 32'h00A5);
    ren_n = 1'b0; rcs_n = 1'b1;
    idle(3);
    ren_n = 1'b1;
    chk("R8 word kept with rcs_n high", 32'(rdata), 32'h00A5);
    chk("R8 ready kept with rcs_n high", 32'(rd_flag), 32'd0);
    rd1(1'b0);
    chk("R6 ready drops on true read", 32'(rd_flag), 32'd1);
    chk("R6 last word stays", 32'(rdata), 32'h00A5);
    idle(4);
    chk("R6 stays not ready", 32'(rd_flag), 32'd1);

    // fall-through capacity is DEPTH+1
    do_reset(1'b1, 1'b0);
    wr1(16'h0200);
    idle(6);
    for (int i = 1; i <= DEPTH; i++) begin
      wr1(WIDTH'(16'h200 + i));
      chk("R5 input-ready during fill", 32'(wr_flag), (i == DEPTH) ? 32'd1 : 32'd0);
    end
    wr1(16'h0BAD);
    chk("R5 stays without room", 32'(wr_flag), 32'd1);
    idle(4);
    for (int i = 0; i <= DEPTH; i++) begin
      chk("R6 presented word", 32'(rdata), 32'(16'h200 + i));
      chk("R6 ready while words remain", 32'(rd_flag), 32'd0);
      rd1(1'b0);
    end
    chk("R6 drained", 32'(rd_flag), 32'd1);
    chk("R6 last data kept", 32'(rdata), 32'(16'h200 + DEPTH));
    idle(6);
    chk("R5 dropped write absent", 32'(rd_flag), 32'd1);

    // independent clocks, both modes
    stream(1'b0);
    stream(1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule